// File: doc/BRIEF.md
# Dual-Channel DAC Command Controller

This block is the digital front end of a two-channel converter driven over a two-wire serial bus. A bit-level slave interface delivers framing events (start, stop) and whole received bytes. The controller checks the first byte of each transfer against the device's type code and its three address pins. It then decodes a command byte and, for write commands, a trailing data byte. It keeps one volatile output register per channel, one nonvolatile copy per channel, and one power-down flag per channel.

A write transaction always loads the output register. The same value reaches the nonvolatile copy only when the master closes the transfer with a stop directly after the data byte. One-byte commands act as soon as the command byte is accepted, and they never touch the nonvolatile copies. These commands force zero scale, force full scale, reload the output from the stored copy, or power a channel down. The nonvolatile store is modelled as a plain register that loads on a write strobe. The strobe and its data are also brought out to the pins so that a real memory can be attached.

Top module: `dual_dac_cmd`

## Requirements
- R1: The first byte after a start is acknowledged only when bits 7..4 equal 0101, bits 3..1 equal `dev_addr_i` and bit 0 is 0. Any other first byte is not acknowledged, and every later byte is ignored until the next start.
- R2: A command byte whose bits 7..4 are 1001, 1010 or 1011 is acknowledged. It selects channel 1, channel 2 or both, and its bits 1..0 become the two most significant bits of the new value.
- R3: The byte after a write command is acknowledged. In the same clock edge, every selected output register loads {command bits 1..0, data byte}.
- R4: A stop received directly after the data byte raises `nv_we_o` for the stop's cycle, with `nv_sel_o` (bit 0 = channel 1) and `nv_data_o` equal to the written value. The selected nonvolatile registers load that value.
- R5: If a start or a further byte follows the data byte instead of a stop, the nonvolatile registers keep their old values and the extra byte is not acknowledged.
- R6: Command 1111_00cc sets the selected channels to zero and command 1111_01cc sets them to full scale (all ones). Here cc = 01 means channel 1, 10 means channel 2 and 11 means both.
- R7: Command 1111_10cc copies each selected channel's nonvolatile value into its output register.
- R8: Command 1111_11cc sets the power-down flag of each selected channel.
- R9: One-byte commands are acknowledged and take effect without a stop, and they never change a nonvolatile register.
- R10: A write, zero, full-scale or recall command that selects a channel clears that channel's power-down flag.
- R11: A command byte matching none of the patterns (including 1111_xx00) is not acknowledged, changes no register, and causes every later byte to be ignored until the next start.
- R12: After reset, both outputs and both nonvolatile copies hold `NV_INIT` (0x200 by default), both power-down flags are low, and `ack_o` is low.
- R13: `ack_o` rises in the cycle after an accepted byte. It stays high until the next byte, start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr_i | input | 3 | Address pin levels compared with byte bits 3..1 |
| bus_start_i | input | 1 | One-cycle start or repeated-start event |
| bus_stop_i | input | 1 | One-cycle stop event |
| byte_vld_i | input | 1 | One-cycle strobe: a received byte is on `byte_i` |
| byte_i | input | 8 | Received byte |
| ack_o | output | 1 | Acknowledge level for the ninth bit clock |
| dac1_o | output | DW | Channel 1 output register |
| dac2_o | output | DW | Channel 2 output register |
| pd1_o | output | 1 | Channel 1 power-down flag |
| pd2_o | output | 1 | Channel 2 power-down flag |
| nv1_o | output | DW | Channel 1 nonvolatile copy |
| nv2_o | output | DW | Channel 2 nonvolatile copy |
| nv_we_o | output | 1 | Nonvolatile write strobe |
| nv_sel_o | output | 2 | Channels written by the strobe |
| nv_data_o | output | DW | Value written by the strobe |

## Verification
The bench concentrates on how each transfer ends. It ends transfers with a stop, with a repeated start, and with a surplus byte. A design that commits on any ending would corrupt the stored copies on repeated starts, and one that commits on none would never update them. Rejected address and command bytes are each followed by a byte that would be valid. A controller that fails to go idle after a rejection would wrongly act on that second byte. The bench also mixes power-down with recall and scale commands, and it recalls right after committed and uncommitted writes. These cases expose a flag that never clears, and a recall that reads the output register instead of the stored copy.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_DATA,
      ST_HOLD
   } seq_st_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_LOAD,
      OP_ZERO,
      OP_FULL,
      OP_RECALL,
      OP_PDOWN
   } chan_op_e;

   localparam logic [3:0] NIB_WR_CH1  = 4'b1001;
   localparam logic [3:0] NIB_WR_CH2  = 4'b1010;
   localparam logic [3:0] NIB_WR_BOTH = 4'b1011;
   localparam logic [3:0] NIB_SHORT   = 4'b1111;

   function automatic chan_op_e short_op(input logic [1:0] kind);
      chan_op_e r;
      case (kind)
         2'b00:   r = OP_ZERO;
         2'b01:   r = OP_FULL;
         2'b10:   r = OP_RECALL;
         default: r = OP_PDOWN;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dacctl_seq.sv
module dacctl_seq
   import dacctl_pkg::*;
#(
   parameter int          DW      = 10,
   parameter int          NCH     = 2,
   parameter logic [3:0]  TYPE_ID = 4'b0101
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [2:0]     dev_addr_i,
   input  logic           bus_start_i,
   input  logic           bus_stop_i,
   input  logic           byte_vld_i,
   input  logic [7:0]     byte_i,
   output logic           ack_o,
   output chan_op_e       op_o,
   output logic [NCH-1:0] op_mask_o,
   output logic [DW-1:0]  op_data_o,
   output logic           nv_we_o,
   output logic [NCH-1:0] nv_mask_o,
   output logic [DW-1:0]  nv_data_o
);

   localparam int HI = DW - 8;

   if (DW < 9 || DW > 12) begin : g_bad_dw
      $error("dacctl_seq: DW must lie in 9..12");
   end
   if (NCH != 2) begin : g_bad_nch
      $error("dacctl_seq: command encoding selects exactly two channels");
   end

   seq_st_e        st_q, st_d;
   logic           ack_q, ack_d;
   logic [NCH-1:0] wr_mask_q, wr_mask_d;
   logic [HI-1:0]  wr_hi_q, wr_hi_d;
   logic [NCH-1:0] hold_mask_q, hold_mask_d;
   logic [DW-1:0]  hold_val_q, hold_val_d;

   logic addr_hit;
   logic is_write;
   logic is_short;

   assign addr_hit = (byte_i[7:4] == TYPE_ID) && (byte_i[3:1] == dev_addr_i) && !byte_i[0];
   assign is_write = (byte_i[7:4] == NIB_WR_CH1) || (byte_i[7:4] == NIB_WR_CH2) ||
                     (byte_i[7:4] == NIB_WR_BOTH);
   assign is_short = (byte_i[7:4] == NIB_SHORT) && (byte_i[1:0] != 2'b00);

   always_comb begin
      st_d        = st_q;
      ack_d       = ack_q;
      wr_mask_d   = wr_mask_q;
      wr_hi_d     = wr_hi_q;
      hold_mask_d = hold_mask_q;
      hold_val_d  = hold_val_q;
      op_o        = OP_NONE;
      op_mask_o   = '0;
      op_data_o   = '0;
      nv_we_o     = 1'b0;
      if (bus_start_i) begin
         st_d  = ST_ADDR;
         ack_d = 1'b0;
      end else if (bus_stop_i) begin
         nv_we_o = (st_q == ST_HOLD);
         st_d    = ST_IDLE;
         ack_d   = 1'b0;
      end else if (byte_vld_i) begin
         ack_d = 1'b0;
         st_d  = ST_IDLE;
         case (st_q)
            ST_ADDR: begin
               if (addr_hit) begin
                  ack_d = 1'b1;
                  st_d  = ST_CMD;
               end
            end
            ST_CMD: begin
               if (is_write) begin
                  ack_d     = 1'b1;
                  wr_mask_d = byte_i[5:4];
                  wr_hi_d   = byte_i[HI-1:0];
                  st_d      = ST_DATA;
               end else if (is_short) begin
                  ack_d     = 1'b1;
                  op_o      = short_op(byte_i[3:2]);
                  op_mask_o = byte_i[1:0];
               end
            end
            ST_DATA: begin
               ack_d       = 1'b1;
               op_o        = OP_LOAD;
               op_mask_o   = wr_mask_q;
               op_data_o   = {wr_hi_q, byte_i};
               hold_mask_d = wr_mask_q;
               hold_val_d  = {wr_hi_q, byte_i};
               st_d        = ST_HOLD;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         ack_q       <= 1'b0;
         wr_mask_q   <= '0;
         wr_hi_q     <= '0;
         hold_mask_q <= '0;
         hold_val_q  <= '0;
      end else begin
         st_q        <= st_d;
         ack_q       <= ack_d;
         wr_mask_q   <= wr_mask_d;
         wr_hi_q     <= wr_hi_d;
         hold_mask_q <= hold_mask_d;
         hold_val_q  <= hold_val_d;
      end
   end

   assign ack_o     = ack_q;
   assign nv_mask_o = hold_mask_q;
   assign nv_data_o = hold_val_q;

   AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> $past(byte_vld_i)); // R13
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start_i || bus_stop_i) |=> !ack_o); // R13
   AST_COMMIT_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      nv_we_o |-> (ack_o && bus_stop_i)); // R4
   AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !bus_start_i && !bus_stop_i && st_q == ST_IDLE) |=> !ack_o); // R11

endmodule

// File: rtl/dacctl_chan.sv
module dacctl_chan
   import dacctl_pkg::*;
#(
   parameter int              DW      = 10,
   parameter logic [DW-1:0]   NV_INIT = DW'(512)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  chan_op_e      op_i,
   input  logic          sel_i,
   input  logic [DW-1:0] data_i,
   input  logic          nv_we_i,
   input  logic [DW-1:0] nv_data_i,
   output logic [DW-1:0] dac_o,
   output logic          pd_o,
   output logic [DW-1:0] nv_o
);

   logic [DW-1:0] dac_q, nv_q;
   logic          pd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q <= NV_INIT;
         pd_q  <= 1'b0;
      end else if (sel_i) begin
         case (op_i)
            OP_LOAD:   begin dac_q <= data_i; pd_q <= 1'b0; end
            OP_ZERO:   begin dac_q <= '0;     pd_q <= 1'b0; end
            OP_FULL:   begin dac_q <= '1;     pd_q <= 1'b0; end
            OP_RECALL: begin dac_q <= nv_q;   pd_q <= 1'b0; end
            OP_PDOWN:  pd_q <= 1'b1;
            default:   ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       nv_q <= NV_INIT;
      else if (nv_we_i) nv_q <= nv_data_i;
   end

   assign dac_o = dac_q;
   assign pd_o  = pd_q;
   assign nv_o  = nv_q;

   AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && op_i == OP_ZERO) |=> (dac_o == '0)); // R6
   AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && op_i == OP_FULL) |=> (dac_o == '1)); // R6
   AST_RECALL_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && op_i == OP_RECALL) |=> (dac_o == $past(nv_o))); // R7
   AST_PD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && op_i == OP_PDOWN) |=> pd_o); // R8
   AST_PD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && op_i != OP_NONE && op_i != OP_PDOWN) |=> !pd_o); // R10
   AST_NV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !nv_we_i |=> $stable(nv_o)); // R9

endmodule

// File: rtl/dual_dac_cmd.sv
module dual_dac_cmd
   import dacctl_pkg::*;
#(
   parameter int             DW      = 10,
   parameter logic [3:0]     TYPE_ID = 4'b0101,
   parameter logic [DW-1:0]  NV_INIT = DW'(512)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    dev_addr_i,
   input  logic          bus_start_i,
   input  logic          bus_stop_i,
   input  logic          byte_vld_i,
   input  logic [7:0]    byte_i,
   output logic          ack_o,
   output logic [DW-1:0] dac1_o,
   output logic [DW-1:0] dac2_o,
   output logic          pd1_o,
   output logic          pd2_o,
   output logic [DW-1:0] nv1_o,
   output logic [DW-1:0] nv2_o,
   output logic          nv_we_o,
   output logic [1:0]    nv_sel_o,
   output logic [DW-1:0] nv_data_o
);

   localparam int NCH = 2;

   chan_op_e       op;
   logic [NCH-1:0] op_mask;
   logic [DW-1:0]  op_data;
   logic           nv_we;
   logic [NCH-1:0] nv_mask;
   logic [DW-1:0]  nv_data;
   logic [DW-1:0]  dac_v [NCH];
   logic [DW-1:0]  nv_v  [NCH];
   logic [NCH-1:0] pd_v;

   dacctl_seq #(.DW(DW), .NCH(NCH), .TYPE_ID(TYPE_ID)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .dev_addr_i  (dev_addr_i),
      .bus_start_i (bus_start_i),
      .bus_stop_i  (bus_stop_i),
      .byte_vld_i  (byte_vld_i),
      .byte_i      (byte_i),
      .ack_o       (ack_o),
      .op_o        (op),
      .op_mask_o   (op_mask),
      .op_data_o   (op_data),
      .nv_we_o     (nv_we),
      .nv_mask_o   (nv_mask),
      .nv_data_o   (nv_data)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dacctl_chan #(.DW(DW), .NV_INIT(NV_INIT)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .op_i      (op),
         .sel_i     (op_mask[c]),
         .data_i    (op_data),
         .nv_we_i   (nv_we && nv_mask[c]),
         .nv_data_i (nv_data),
         .dac_o     (dac_v[c]),
         .pd_o      (pd_v[c]),
         .nv_o      (nv_v[c])
      );
   end

   assign dac1_o    = dac_v[0];
   assign dac2_o    = dac_v[1];
   assign nv1_o     = nv_v[0];
   assign nv2_o     = nv_v[1];
   assign pd1_o     = pd_v[0];
   assign pd2_o     = pd_v[1];
   assign nv_we_o   = nv_we;
   assign nv_sel_o  = nv_mask;
   assign nv_data_o = nv_data;

   AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD && op_mask[0]) |=> (dac1_o == $past(op_data))); // R3
   AST_NV_MATCHES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (nv_we_o && nv_sel_o[1]) |=> (nv2_o == $past(nv_data_o))); // R4

endmodule

// File: tb/dual_dac_cmd_test.sv
module dual_dac_cmd_test;

   localparam logic [2:0] ADDR = 3'b101;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_start = 1'b0, bus_stop = 1'b0, byte_vld = 1'b0;
   logic [7:0] byte_d = 8'h00;
   logic       ack, pd1, pd2, nv_we;
   logic [9:0] dac1, dac2, nv1, nv2, nv_data;
   logic [1:0] nv_sel;

   int checks = 0;
   int errors = 0;

   logic [9:0] m_dac [2];
   logic [9:0] m_nv  [2];
   logic       m_pd  [2];

   always #2 clk = ~clk;

   dual_dac_cmd uut (
      .clk(clk), .rst_n(rst_n), .dev_addr_i(ADDR),
      .bus_start_i(bus_start), .bus_stop_i(bus_stop),
      .byte_vld_i(byte_vld), .byte_i(byte_d), .ack_o(ack),
      .dac1_o(dac1), .dac2_o(dac2), .pd1_o(pd1), .pd2_o(pd2),
      .nv1_o(nv1), .nv2_o(nv2), .nv_we_o(nv_we), .nv_sel_o(nv_sel),
      .nv_data_o(nv_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic addr_ok(input logic [7:0] b);
      return b[7:4] == 4'b0101 && b[3:1] == ADDR && !b[0];
   endfunction

   function automatic logic cmd_ok(input logic [7:0] b);
      return b[7:4] == 4'b1001 || b[7:4] == 4'b1010 || b[7:4] == 4'b1011 ||
             (b[7:4] == 4'b1111 && b[1:0] != 2'b00);
   endfunction

   task automatic check_state(input string req);
      chk({req, " dac1"}, 32'(dac1), 32'(m_dac[0]));
      chk({req, " dac2"}, 32'(dac2), 32'(m_dac[1]));
      chk({req, " nv1"},  32'(nv1),  32'(m_nv[0]));
      chk({req, " nv2"},  32'(nv2),  32'(m_nv[1]));
      chk({req, " pd1"},  32'(pd1),  32'(m_pd[0]));
      chk({req, " pd2"},  32'(pd2),  32'(m_pd[1]));
   endtask

   task automatic do_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
      chk("R13 ack low after start", 32'(ack), 0);
   endtask

   task automatic do_stop(input logic commit, input logic [1:0] msk, input logic [9:0] val);
      @(negedge clk); bus_stop = 1'b1;
      #1;
      chk("R4 nv_we at stop", 32'(nv_we), 32'(commit));
      if (commit) begin
         chk("R4 nv_sel", 32'(nv_sel), 32'(msk));
         chk("R4 nv_data", 32'(nv_data), 32'(val));
      end
      @(negedge clk); bus_stop = 1'b0;
      chk("R13 ack low after stop", 32'(ack), 0);
   endtask

   task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
      @(negedge clk); byte_vld = 1'b1; byte_d = b;
      @(negedge clk); byte_vld = 1'b0;
      chk(req, 32'(ack), 32'(exp_ack));
   endtask

   task automatic apply_short(input logic [7:0] b);
      for (int c = 0; c < 2; c++) begin
         if (b[c]) begin
            case (b[3:2])
               2'b00: begin m_dac[c] = '0;      m_pd[c] = 1'b0; end
               2'b01: begin m_dac[c] = '1;      m_pd[c] = 1'b0; end
               2'b10: begin m_dac[c] = m_nv[c]; m_pd[c] = 1'b0; end
               default: m_pd[c] = 1'b1;
            endcase
         end
      end
   endtask

   // ending: 0 stop, 1 repeated start then stop, 2 extra byte then stop
   task automatic write_txn(input logic [1:0] msk, input logic [9:0] val, input int ending);
      logic [7:0] cb = {2'b10, msk, 2'b00, val[9:8]};
      do_start();
      send({4'b0101, ADDR, 1'b0}, 1'b1, "R1 address ack");
      send(cb, 1'b1, "R2 write command ack");
      send(val[7:0], 1'b1, "R3 data ack");
      for (int c = 0; c < 2; c++) if (msk[c]) begin m_dac[c] = val; m_pd[c] = 1'b0; end
      check_state("R3 R10 after data");
      if (ending == 0) begin
         do_stop(1'b1, msk, val);
         for (int c = 0; c < 2; c++) if (msk[c]) m_nv[c] = val;
         check_state("R4 committed");
      end else if (ending == 1) begin
         do_start();
         do_stop(1'b0, msk, val);
         check_state("R5 restart keeps nv");
      end else begin
         send(8'hA5, 1'b0, "R5 extra byte not acked");
         do_stop(1'b0, msk, val);
         check_state("R5 extra byte keeps nv");
      end
   endtask

   task automatic short_txn(input logic [7:0] b, input logic with_stop);
      do_start();
      send({4'b0101, ADDR, 1'b0}, 1'b1, "R1 address ack");
      send(b, 1'b1, "R9 short command ack");
      apply_short(b);
      check_state("R6 R7 R8 R9 short effect");
      if (with_stop) do_stop(1'b0, 2'b00, 10'd0);
      check_state("R9 no nv change");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] b;
      void'($urandom(32'd4242));
      for (int c = 0; c < 2; c++) begin m_dac[c] = 10'h200; m_nv[c] = 10'h200; m_pd[c] = 1'b0; end
      repeat (3) @(negedge clk);
      chk("R12 ack reset", 32'(ack), 0);
      check_state("R12 reset");
      rst_n = 1'b1;
      @(negedge clk);

      write_txn(2'b01, 10'h2C5, 0);
      write_txn(2'b10, 10'h13A, 1);
      write_txn(2'b11, 10'h3F0, 2);
      short_txn(8'hFB, 1'b1);                       // R7 recall both
      short_txn(8'hFF, 1'b0);                       // R8 power down both
      short_txn(8'hF5, 1'b1);                       // R6 full ch1, R10 clears pd1
      chk("R10 pd2 still set", 32'(pd2), 1);
      short_txn(8'hF2, 1'b0);                       // R6 zero ch2, R10
      // R1 wrong address, then a valid command byte is ignored
      do_start();
      send({4'b0101, ~ADDR, 1'b0}, 1'b0, "R1 wrong address no ack");
      send(8'hF3, 1'b0, "R1 later byte ignored");
      check_state("R1 no effect");
      // R1 read bit set
      do_start();
      send({4'b0101, ADDR, 1'b1}, 1'b0, "R1 read bit no ack");
      send(8'hF7, 1'b0, "R1 later byte ignored");
      do_stop(1'b0, 2'b00, 10'd0);
      check_state("R1 no effect");
      // R11 bad command, then a valid byte is ignored
      do_start();
      send({4'b0101, ADDR, 1'b0}, 1'b1, "R1 address ack");
      send(8'hF0, 1'b0, "R11 bad command no ack");
      send(8'hF7, 1'b0, "R11 later byte ignored");
      do_stop(1'b0, 2'b00, 10'd0);
      check_state("R11 no effect");

      for (int i = 0; i < 400; i++) begin
         int kind = $urandom_range(0, 4);
         case (kind)
            0, 1: write_txn(2'($urandom_range(1, 3)), 10'($urandom), $urandom_range(0, 2));
            2: begin
               b = {4'b1111, 4'($urandom)};
               if (b[1:0] == 2'b00) b[0] = 1'b1;
               short_txn(b, 1'($urandom));
            end
            3: begin
               b = 8'($urandom);
               do_start();
               send(b, addr_ok(b), "R1 random address");
               if (addr_ok(b)) begin
                  b = 8'($urandom);
                  if (cmd_ok(b)) b = 8'h00;
                  send(b, 1'b0, "R11 random bad command");
               end else begin
                  send(8'hFB, 1'b0, "R1 ignored after mismatch");
               end
               do_stop(1'b0, 2'b00, 10'd0);
               check_state("R1 R11 random no effect");
            end
            default: begin
               short_txn({4'b1111, 2'b11, 2'($urandom_range(1, 3))}, 1'b1);
               short_txn({4'b1111, 2'b10, 2'($urandom_range(1, 3))}, 1'b0);
            end
         endcase
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule